// File: doc/BRIEF.md
# UART FIFO Status, Interrupt and DMA-Ready Controller

This block produces the status, interrupt and DMA-handshake signals that surround the receive and transmit byte queues of one UART channel. It does not hold the data bytes. The queue storage, the serial shifters and the baud logic stay outside. Those parts report to the block through fill counts, push and pop strobes, a shift-register-empty flag and four error flags per received character.

The block owns a small control register and an interrupt-enable register. The control register enables the queues, requests a flush of either queue, selects the receive trigger depth and selects one of two DMA signalling modes. The outputs are the following:
- an eight-bit line-status word;
- one interrupt request and a four-bit identification code;
- two active-low ready pins for a DMA engine.

To report the error flags of the oldest received byte, the block keeps its own shadow queue of the per-byte error tags. This queue advances in step with the external receive storage.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset the queues are disabled, all interrupt enables are 0 and DMA mode 0 is selected. With both counts at zero and the shift register empty, `line_status` is 8'h60, `irq` is 0, `int_id` is 4'b0001, `txrdy_n` is 0 and `rxrdy_n` is 1.
- R2: `line_status[0]` is 1 exactly while the receive count is non-zero. It is 0 in the cycle of a receive flush.
- R3: The receive trigger depth is taken from `fcr_wdata[5:4]`: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. This applies only while the queues are enabled (`fcr_wdata[0]`=1). Otherwise the depth is 1. With `ier_wdata[0]` set, `irq` is high and `int_id` is 4'b0100 while the count is at or above the depth and no higher source applies. Both drop in the cycle the count falls below the depth.
- R4: A transmit-empty pending flag sets on any of three events:
  - a pop that takes the transmit count from 1 to 0 without a push in the same cycle;
  - a transmit flush;
  - a write that raises `ier_wdata[1]` while the transmit queue is empty.

  The flag clears on a transmit push, or on `iid_rd` in a cycle where `int_id` shows 4'b0010. A set event wins over a clear in the same cycle. With `ier[1]` set, the flag is shown as code 4'b0010.
- R5: `line_status[5]` is 1 while the transmit count is zero. `line_status[6]` is 1 only while that is true and `tsr_empty` is also 1.
- R6: `line_status[4:1]` carries the four error flags stored with the oldest byte in the receive queue, and is 0 when the queue is empty. With `ier_wdata[2]` set, non-zero flags raise `irq` with code 4'b0110. The priority order is 4'b0110 first, then 4'b0100, then 4'b0010.
- R7: `line_status[7]` is 1 while the queues are enabled and at least one byte with non-zero flags remains in the receive queue. It clears only once every such byte has been popped.
- R8: In DMA mode 0 (`fcr_wdata[3]`=0, or queues disabled), `txrdy_n` is low exactly while the transmit count is zero. `rxrdy_n` is low exactly while the receive count is non-zero.
- R9: In DMA mode 1 (`fcr_wdata[3]`=1 with queues enabled), `txrdy_n` is low while the transmit count is below DEPTH. `rxrdy_n` goes low when the receive count reaches the trigger depth and stays low, even below that depth, until the count reaches zero.
- R10: While all four interrupt-enable bits are 0, `irq` stays 0 and `int_id` is 4'b0001. The line-status bits keep updating.
- R11: A control write with bit 1 set pulses `rx_flush` for that cycle only. In that same cycle it forces the receive status to empty: `line_status[0]`, `line_status[4:1]` and `line_status[7]` go to 0 and `rxrdy_n` goes to 1. It also discards the shadow error tags and any push made in that cycle. Bit 2 does the same for the transmit side (`tx_flush`, `line_status[5]`=1). Neither flush bit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | Control register write strobe |
| fcr_wdata | input | 6 | [0] queue enable, [1] receive flush, [2] transmit flush, [3] DMA mode, [5:4] trigger select |
| ier_wr | input | 1 | Interrupt-enable write strobe |
| ier_wdata | input | 4 | [0] receive data, [1] transmit empty, [2] line status, [3] modem (no source here) |
| iid_rd | input | 1 | Interrupt-identification read strobe |
| rx_push | input | 1 | A character enters the receive queue |
| rx_push_err | input | 4 | Error flags of the character being pushed |
| rx_pop | input | 1 | The oldest receive byte is read out |
| rx_count | input | CW | Receive queue fill count |
| tx_push | input | 1 | Write to the transmit holding register |
| tx_pop | input | 1 | Shift register takes a transmit byte |
| tx_count | input | CW | Transmit queue fill count |
| tsr_empty | input | 1 | Transmit shift register idle |
| rx_flush | output | 1 | Flush pulse to receive storage |
| tx_flush | output | 1 | Flush pulse to transmit storage |
| line_status | output | 8 | Line-status word |
| irq | output | 1 | Interrupt request |
| int_id | output | 4 | Interrupt identification code |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |

## Verification
Two functions can fall in the same cycle: the transmit-empty flag being set, and the same flag being cleared by an identification read. The bench provokes this with a transmit flush issued in the very cycle that `iid_rd` samples code 4'b0010. The scoreboard then expects the code to remain 4'b0010 on the following cycle, because the set event wins. A second collision is a receive flush written in the same cycle as a push. In that case the expected status is empty both in that cycle and in the next.

// File: rtl/uart_fifo_status_pkg.sv
package uart_fifo_status_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_LINE    = 4'b0110,
        IID_RXTRIG  = 4'b0100,
        IID_TXEMPTY = 4'b0010
    } iid_e;

    typedef struct packed {
        logic       fen;
        logic       dma1;
        logic [1:0] tsel;
        logic [3:0] ier;
    } cfg_t;

    function automatic int trig_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ufs_cfg_regs.sv
module ufs_cfg_regs
    import uart_fifo_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fcr_wr,
    input  logic [5:0] fcr_wdata,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    output cfg_t       cfg,
    output logic       tx_ie_rise
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (fcr_wr) begin
            cfg_d.fen  = fcr_wdata[0];
            cfg_d.dma1 = fcr_wdata[3];
            cfg_d.tsel = fcr_wdata[5:4];
        end
        if (ier_wr) begin
            cfg_d.ier = ier_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg        = cfg_q;
    assign tx_ie_rise = ier_wr & ier_wdata[1] & ~cfg_q.ier[1];

endmodule

// File: rtl/ufs_err_tags.sv
module ufs_err_tags #(
    parameter int DEPTH = 16,
    parameter int EW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [EW-1:0] push_err,
    input  logic          pop,
    output logic [EW-1:0] head_err,
    output logic          any_err
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic [CW-1:0]            ecnt;
    } tag_st_t;

    tag_st_t st_d, st_q;
    logic    pop_ok, push_ok;
    logic [EW-1:0] head;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        head    = st_q.mem[st_q.rp];
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && ((st_q.cnt != FULL) || pop_ok);
        if (flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.cnt  = '0;
            st_d.ecnt = '0;
        end else begin
            if (pop_ok) begin
                st_d.rp = nxt(st_q.rp);
                if (|head) st_d.ecnt = st_d.ecnt - 1'b1;
            end
            if (push_ok) begin
                st_d.mem[st_q.wp] = push_err;
                st_d.wp = nxt(st_q.wp);
                if (|push_err) st_d.ecnt = st_d.ecnt + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_err = (st_q.cnt != '0) ? head : '0;
    assign any_err  = (st_q.ecnt != '0);

endmodule

// File: rtl/ufs_irq_ctrl.sv
module ufs_irq_ctrl
    import uart_fifo_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ier,
    input  logic       line_err,
    input  logic       rx_hit,
    input  logic       tx_set,
    input  logic       tx_push,
    input  logic       iid_rd,
    output logic       irq,
    output logic [3:0] int_id
);
    typedef struct packed {
        logic tx_pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    iid_e    id;
    logic    src_line, src_rx, src_tx;

    always_comb begin
        src_line = ier[2] & line_err;
        src_rx   = ier[0] & rx_hit;
        src_tx   = ier[1] & st_q.tx_pend;
        if (src_line)    id = IID_LINE;
        else if (src_rx) id = IID_RXTRIG;
        else if (src_tx) id = IID_TXEMPTY;
        else             id = IID_NONE;

        st_d = st_q;
        if (tx_set)
            st_d.tx_pend = 1'b1;
        else if (tx_push || (iid_rd && id == IID_TXEMPTY))
            st_d.tx_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq    = (|ier) & (src_line | src_rx | src_tx);
    assign int_id = id;

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
    import uart_fifo_status_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fcr_wr,
    input  logic [5:0]    fcr_wdata,
    input  logic          ier_wr,
    input  logic [3:0]    ier_wdata,
    input  logic          iid_rd,
    input  logic          rx_push,
    input  logic [3:0]    rx_push_err,
    input  logic          rx_pop,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic [CW-1:0] tx_count,
    input  logic          tsr_empty,
    output logic          rx_flush,
    output logic          tx_flush,
    output logic [7:0]    line_status,
    output logic          irq,
    output logic [3:0]    int_id,
    output logic          txrdy_n,
    output logic          rxrdy_n
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic hold;
    } dma_st_t;

    cfg_t          cfg;
    logic          tx_ie_rise;
    logic [3:0]    head_err;
    logic          any_err;
    logic          rx_live, tx_empty, rx_hit, mode1, tx_set;
    logic [CW-1:0] trig_lvl;
    logic [3:0]    head_vis;
    dma_st_t       dma_d, dma_q;

    ufs_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .fcr_wr     (fcr_wr),
        .fcr_wdata  (fcr_wdata),
        .ier_wr     (ier_wr),
        .ier_wdata  (ier_wdata),
        .cfg        (cfg),
        .tx_ie_rise (tx_ie_rise)
    );

    ufs_err_tags #(.DEPTH(DEPTH), .EW(4)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .push     (rx_push),
        .push_err (rx_push_err),
        .pop      (rx_pop),
        .head_err (head_err),
        .any_err  (any_err)
    );

    always_comb begin
        rx_flush = fcr_wr & fcr_wdata[1];
        tx_flush = fcr_wr & fcr_wdata[2];
        rx_live  = (rx_count != '0) & ~rx_flush;
        tx_empty = (tx_count == '0) | tx_flush;
        trig_lvl = cfg.fen ? CW'(trig_bytes(cfg.tsel)) : ONE;
        rx_hit   = rx_live & (rx_count >= trig_lvl);
        head_vis = rx_live ? head_err : 4'h0;
        mode1    = cfg.fen & cfg.dma1;
        tx_set   = (tx_pop & ~tx_push & (tx_count == ONE)) | tx_flush
                 | (tx_ie_rise & tx_empty);
        line_status = {cfg.fen & any_err & ~rx_flush,
                       tx_empty & tsr_empty,
                       tx_empty,
                       head_vis,
                       rx_live};
    end

    ufs_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ier      (cfg.ier),
        .line_err (|head_vis),
        .rx_hit   (rx_hit),
        .tx_set   (tx_set),
        .tx_push  (tx_push),
        .iid_rd   (iid_rd),
        .irq      (irq),
        .int_id   (int_id)
    );

    always_comb begin
        dma_d.hold = mode1 & (rx_hit | (dma_q.hold & rx_live));
        if (mode1) begin
            txrdy_n = ~((tx_count < FULL) | tx_flush);
            rxrdy_n = ~(rx_hit | (dma_q.hold & rx_live));
        end else begin
            txrdy_n = ~tx_empty;
            rxrdy_n = ~rx_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= dma_d;
    end

endmodule

// File: rtl/ufs_chk.sv
module ufs_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fcr_wr,
    input logic [5:0]    fcr_wdata,
    input logic          ier_wr,
    input logic [3:0]    ier_wdata,
    input logic          tx_push,
    input logic          tsr_empty,
    input logic [CW-1:0] rx_count,
    input logic [7:0]    line_status,
    input logic          irq,
    input logic [3:0]    int_id,
    input logic          rxrdy_n,
    input logic [3:0]    ier_q,
    input logic          mode1
);
    AST_POLL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && ier_wdata == 4'h0) |=> !irq); // R10

    AST_TXPUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !fcr_wr && !ier_wr) |=> (int_id != 4'b0010)); // R4

    AST_RXFLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[1]) |-> (!line_status[0] && line_status[4:1] == 4'h0 && rxrdy_n)); // R11

    AST_LSR6_NEEDS_TSR: assert property (@(posedge clk) disable iff (!rst_n)
        !tsr_empty |-> !line_status[6]); // R5

    AST_RXID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == 4'b0100) |-> (rx_count != '0)); // R3

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && line_status[4:1] != 4'h0) |-> (int_id == 4'b0110)); // R6

    AST_M1_RXRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && !rxrdy_n && !fcr_wr) |=>
        (rx_count == '0 || !rxrdy_n || (fcr_wr && fcr_wdata[1]))); // R9

endmodule

bind uart_fifo_status ufs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fcr_wr      (fcr_wr),
    .fcr_wdata   (fcr_wdata),
    .ier_wr      (ier_wr),
    .ier_wdata   (ier_wdata),
    .tx_push     (tx_push),
    .tsr_empty   (tsr_empty),
    .rx_count    (rx_count),
    .line_status (line_status),
    .irq         (irq),
    .int_id      (int_id),
    .rxrdy_n     (rxrdy_n),
    .ier_q       (cfg.ier),
    .mode1       (mode1)
);

// File: tb/tb_uart_fifo_status.sv
`timescale 1ns/1ps
module tb_uart_fifo_status;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          fcr_wr = 0, ier_wr = 0, iid_rd = 0;
    logic [5:0]    fcr_wdata = '0;
    logic [3:0]    ier_wdata = '0;
    logic          rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, tsr_empty = 1;
    logic [3:0]    rx_push_err = '0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic          rx_flush, tx_flush, irq, txrdy_n, rxrdy_n;
    logic [7:0]    line_status;
    logic [3:0]    int_id;

    uart_fifo_status #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .ier_wr(ier_wr), .ier_wdata(ier_wdata), .iid_rd(iid_rd),
        .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_count(rx_count),
        .tx_push(tx_push), .tx_pop(tx_pop), .tx_count(tx_count), .tsr_empty(tsr_empty),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .line_status(line_status), .irq(irq),
        .int_id(int_id), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
    );

    // behavioural model state
    logic       m_fen = 0, m_dma = 0, m_txp = 0, m_hold = 0;
    logic [1:0] m_sel = 0;
    logic [3:0] m_ier = 0;
    logic [3:0] m_tags[$];
    string      cur = "R1";
    int n_chk = 0, n_err = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic [7:0] lsr;
        logic       irq;
        logic [3:0] id;
        logic       txn;
        logic       rxn;
        logic       rxf;
        logic       txf;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        exp_t e;
        logic rxf, txf, ne, txe, hit, m1, ls, rd, th, anyerr, tset;
        logic [3:0] head, id;
        int trig;
        @(negedge clk);
        rxf  = fcr_wr & fcr_wdata[1];
        txf  = fcr_wr & fcr_wdata[2];
        ne   = (rx_count != 0) && !rxf;
        txe  = (tx_count == 0) || txf;
        trig = m_fen ? (m_sel == 0 ? 1 : m_sel == 1 ? 4 : m_sel == 2 ? 8 : 14) : 1;
        hit  = ne && (int'(rx_count) >= trig);
        head = ne ? m_tags[0] : 4'h0;
        anyerr = 0;
        foreach (m_tags[i]) if (m_tags[i] != 0) anyerr = 1;
        ls = m_ier[2] && head != 0;
        rd = m_ier[0] && hit;
        th = m_ier[1] && m_txp;
        id = ls ? 4'b0110 : rd ? 4'b0100 : th ? 4'b0010 : 4'b0001;
        m1 = m_fen && m_dma;
        e.req = cur;
        e.lsr = {m_fen && anyerr && !rxf, txe && tsr_empty, txe, head, ne};
        e.irq = ls || rd || th;
        e.id  = id;
        e.txn = m1 ? !((int'(tx_count) < DEPTH) || txf) : !txe;
        e.rxn = m1 ? !(hit || (m_hold && ne)) : !ne;
        e.rxf = rxf;
        e.txf = txf;
        sbq.push_back(e);
        @(posedge clk); #1;
        // model update, using the inputs of the cycle just ended
        tset = (tx_pop && !tx_push && tx_count == 1) || txf
             || (ier_wr && ier_wdata[1] && !m_ier[1] && txe);
        if (tset) m_txp = 1;
        else if (tx_push || (iid_rd && id == 4'b0010)) m_txp = 0;
        m_hold = m1 && (hit || (m_hold && ne));
        if (rxf) begin
            rx_count = 0; m_tags.delete();
        end else begin
            logic popok, pushok;
            popok  = rx_pop && rx_count != 0;
            pushok = rx_push && (rx_count != DEPTH || popok);
            if (popok) void'(m_tags.pop_front());
            if (pushok) m_tags.push_back(rx_push_err);
            rx_count = CW'(m_tags.size());
        end
        if (txf) tx_count = 0;
        else begin
            logic popok, pushok;
            popok  = tx_pop && tx_count != 0;
            pushok = tx_push && (tx_count != DEPTH || popok);
            tx_count = tx_count + CW'(pushok) - CW'(popok);
        end
        if (fcr_wr) begin m_fen = fcr_wdata[0]; m_dma = fcr_wdata[3]; m_sel = fcr_wdata[5:4]; end
        if (ier_wr) m_ier = ier_wdata;
        fcr_wr = 0; ier_wr = 0; iid_rd = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        rx_push_err = 0;
    endtask

    // monitor: pops expectations and compares against outputs
    initial begin
        forever begin
            @(negedge clk); #2;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.req, "line_status", line_status, e.lsr);
                chk(e.req, "irq", {7'b0, irq}, {7'b0, e.irq});
                chk(e.req, "int_id", {4'b0, int_id}, {4'b0, e.id});
                chk(e.req, "txrdy_n", {7'b0, txrdy_n}, {7'b0, e.txn});
                chk(e.req, "rxrdy_n", {7'b0, rxrdy_n}, {7'b0, e.rxn});
                chk(e.req, "flush", {6'b0, rx_flush, tx_flush}, {6'b0, e.rxf, e.txf});
            end
        end
    end

    task automatic w_fcr(logic [5:0] v); fcr_wr = 1; fcr_wdata = v; cyc(); endtask
    task automatic w_ier(logic [3:0] v); ier_wr = 1; ier_wdata = v; cyc(); endtask
    task automatic rpush(int n, logic [3:0] err);
        for (int i = 0; i < n; i++) begin rx_push = 1; rx_push_err = err; cyc(); end
    endtask
    task automatic rpop(int n);
        for (int i = 0; i < n; i++) begin rx_pop = 1; cyc(); end
    endtask
    task automatic tpush(int n);
        for (int i = 0; i < n; i++) begin tx_push = 1; cyc(); end
    endtask
    task automatic tpop(int n);
        for (int i = 0; i < n; i++) begin tx_pop = 1; cyc(); end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur = "R1"; cyc(); cyc();
        // mode 0, queues disabled
        cur = "R8"; tpush(1); cyc(); tpop(1); cyc(); rpush(1, 0); cyc(); rpop(1); cyc();
        cur = "R5"; tsr_empty = 0; tpush(1); cyc(); tpop(1); cyc(); tsr_empty = 1; cyc();
        // trigger depths
        cur = "R3"; w_fcr(6'h11); w_ier(4'h1); rpush(5, 0);
        cur = "R2"; rpop(5); cyc();
        cur = "R3"; w_fcr(6'h21); rpush(9, 0); rpop(2); rpop(7);
        w_fcr(6'h31); rpush(17, 0); rpop(3);
        cur = "R11"; rx_push = 1; w_fcr(6'h33); cyc();
        cur = "R3"; w_fcr(6'h01); rpush(1, 0); rpop(1); cyc();
        // transmit pending flag
        cur = "R4"; w_ier(4'h0); w_ier(4'h2); cyc(); iid_rd = 1; cyc(); cyc();
        tpush(2); tpop(1); tpop(1); cyc(); tpush(1); cyc(); tpop(1);
        iid_rd = 1; w_fcr(6'h05); cyc(); iid_rd = 1; cyc(); cyc();
        tx_push = 1; tx_pop = 1; cyc(); tpop(1); cyc();
        // error tags and priority
        cur = "R6"; w_ier(4'h7); w_fcr(6'h11); rpush(1, 4'b0010); rpush(3, 0); cyc();
        cur = "R7"; rpop(1); cyc(); rpush(1, 4'b1000); rpop(2); cyc(); rpop(1); rpop(1); cyc();
        // DMA mode 1
        cur = "R9"; w_ier(4'h0); w_fcr(6'h19); rpush(4, 0); rpop(2); rx_push = 1; rx_pop = 1; cyc();
        rpop(2); cyc(); tpush(16); tpush(1); tpop(1); cyc(); tpop(15); cyc();
        cur = "R8"; w_fcr(6'h11); rpush(2, 0); rpop(2); cyc();
        // polled mode
        cur = "R10"; w_ier(4'h0); rpush(15, 4'b0100); tpush(1); tpop(1); w_fcr(6'h05); cyc();
        // flushes
        cur = "R11"; w_ier(4'h7); w_fcr(6'h13); cyc(); tpush(3); w_fcr(6'h17); cyc(); cyc();
        rpush(2, 4'b0001); cyc();
        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule